// File: doc/BRIEF.md
# Four-Channel DMA Priority Arbiter

This block decides which of four DMA channels owns the bus. Each channel raises a peripheral request as a one-cycle pulse. The arbiter latches that pulse into a pending bit and keeps it until the transfer that serves the request has finished. When no grant is held, the arbiter looks at the pending bits and picks one channel according to the active priority scheme. It then holds that one-hot grant until the transfer engine reports that the work for that channel is complete.

A two-bit mode input selects the priority scheme. Two schemes use a fixed channel order. The third is a rotating order in which the channel just served falls to the bottom after every transfer unit. Each channel also has a bus-mode bit that sets when it lets go of the bus. A cycle-steal channel releases after every unit. A burst channel releases only at the unit that ends its burst. The current order is shown on an output as a list of channel numbers, so the rest of the controller can display or trace it.

Top module: `dma_prio_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `grant` and `pend` are all zeros and the rotating order is channel 0, 1, 2, 3 from highest to lowest. `prio_order` packs the order with the highest-ranked channel number in bits [1:0], the next in [3:2], then [5:4], with the lowest in [7:6]. After reset in round-robin mode it therefore reads 8'hE4.
- R2: `prio_mode` = 2'b00 selects fixed order 0 > 1 > 2 > 3, and `prio_order` reads 8'hE4. Among several pending channels, the highest-ranked one is granted.
- R3: `prio_mode` = 2'b01 selects fixed order 0 > 2 > 3 > 1, and `prio_order` reads 8'h78.
- R4: `prio_mode` = 2'b10 or 2'b11 selects round-robin. On every `unit_done` while a grant is held, the order changes in the next cycle: the granted channel moves to the lowest rank and the other channels keep their relative order. In fixed modes the rotating order is not changed.
- R5: A one-cycle pulse on `req_set[i]` sets `pend[i]` in the next cycle. The bit then stays set until the channel's release clears it.
- R6: A channel with `burst_mode[i]` = 0 (cycle steal) is released by any `unit_done` while it holds the grant. In the next cycle both `grant` and its `pend` bit are zero.
- R7: A channel with `burst_mode[i]` = 1 keeps its grant and its pending bit through `unit_done` pulses that have `burst_last` = 0. The channel is released only by `unit_done` together with `burst_last` = 1.
- R8: `grant` is one-hot or zero. A held grant does not change until it is released. A new choice is made in the cycle after the grant drops, from the pending bits of that cycle.
- R9: If no grant is held, `unit_done` has no effect. If nothing is pending, `grant` stays zero.
- R10: If a channel's `req_set` pulse arrives in the same cycle as that channel's release, its `pend` bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prio_mode | input | 2 | Priority scheme: 00 fixed A, 01 fixed B, 1x round-robin |
| req_set | input | 4 | Per-channel peripheral request pulses |
| burst_mode | input | 4 | Per-channel bus mode: 0 cycle steal, 1 burst |
| unit_done | input | 1 | One transfer unit finished for the granted channel |
| burst_last | input | 1 | Qualifies `unit_done` as the end of a burst |
| grant | output | 4 | One-hot bus grant |
| pend | output | 4 | Latched pending requests |
| prio_order | output | 8 | Current order, 2 bits per rank, highest rank in the low bits |

## Verification
The assertions check on every cycle:
- the grant is at most one-hot and is always backed by a pending bit;
- a held grant stays stable until a release drops it to zero;
- an idle arbiter with nothing pending keeps the grant at zero;
- `prio_order` is always a permutation of the four channel numbers;
- fixed order A shows its fixed value.

Only the bench scenarios can show these behaviours:
- the order in which pending channels are served;
- the exact rotation of the round-robin order after each unit;
- how bursts behave compared with cycle-steal transfers;
- a request pulse arriving in the same cycle as a release.

The bench shows them by comparing against a queue-based reference on every clock.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    PRIO_FIX_A = 2'b00,
    PRIO_FIX_B = 2'b01,
    PRIO_RR0   = 2'b10,
    PRIO_RR1   = 2'b11
  } prio_mode_e;
endpackage

// File: rtl/dma_arb_req_latch.sv
module dma_arb_req_latch #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] pend_o
);
  logic [NUM_CH-1:0] pend_q, pend_d;
  logic              pend_en;

  always_comb begin
    pend_en = (|set_i) | (|clr_i);
    pend_d  = (pend_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dma_arb_rr_order.sv
module dma_arb_rr_order #(
  parameter int NUM_CH = 4,
  localparam int IDW = $clog2(NUM_CH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rot_en,
  input  logic [IDW-1:0]        rot_ch,
  output logic [NUM_CH*IDW-1:0] order_o
);
  logic [IDW-1:0] ord_q   [NUM_CH];
  logic [IDW-1:0] ord_d   [NUM_CH];
  logic [IDW-1:0] ord_ext [NUM_CH+1];
  int unsigned    hit_pos;

  always_comb begin
    hit_pos = NUM_CH - 1;
    for (int p = NUM_CH - 1; p >= 0; p--) begin
      if (ord_q[p] == rot_ch) hit_pos = p;
    end
    for (int p = 0; p < NUM_CH; p++) ord_ext[p] = ord_q[p];
    ord_ext[NUM_CH] = rot_ch;
    for (int p = 0; p < NUM_CH; p++) begin
      ord_d[p] = (p >= hit_pos) ? ord_ext[p+1] : ord_ext[p];
    end
  end

  for (genvar p = 0; p < NUM_CH; p++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ord_q[p] <= IDW'(p);
      else if (rot_en) ord_q[p] <= ord_d[p];
    end
    assign order_o[p*IDW +: IDW] = ord_q[p];
  end
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int NUM_CH = 4,
  localparam int IDW = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0]     req_i,
  input  logic [NUM_CH*IDW-1:0] order_i,
  output logic [NUM_CH-1:0]     gnt_o
);
  logic           found;
  logic [IDW-1:0] ch;

  always_comb begin
    gnt_o = '0;
    found = 1'b0;
    for (int p = 0; p < NUM_CH; p++) begin
      ch = order_i[p*IDW +: IDW];
      if (!found && req_i[ch]) begin
        gnt_o[ch] = 1'b1;
        found     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int IDW = $clog2(NUM_CH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            prio_mode,
  input  logic [NUM_CH-1:0]     req_set,
  input  logic [NUM_CH-1:0]     burst_mode,
  input  logic                  unit_done,
  input  logic                  burst_last,
  output logic [NUM_CH-1:0]     grant,
  output logic [NUM_CH-1:0]     pend,
  output logic [NUM_CH*IDW-1:0] prio_order
);
  logic [NUM_CH*IDW-1:0] ord_fix_a, ord_fix_b, ord_rr, ord_eff;
  logic [NUM_CH-1:0]     gnt_q, gnt_d, pick_gnt, pend_q, clr_vec;
  logic                  gnt_en, held, rel, rr_sel, rot_en;
  logic [IDW-1:0]        gnt_id;
  prio_mode_e            mode;

  for (genvar p = 0; p < NUM_CH; p++) begin : g_fixed
    assign ord_fix_a[p*IDW +: IDW] = IDW'(p);
    if (p == 0) begin : g_top
      assign ord_fix_b[p*IDW +: IDW] = IDW'(0);
    end else if (p == NUM_CH - 1) begin : g_low
      assign ord_fix_b[p*IDW +: IDW] = IDW'(1);
    end else begin : g_mid
      assign ord_fix_b[p*IDW +: IDW] = IDW'(p + 1);
    end
  end

  always_comb begin
    mode   = prio_mode_e'(prio_mode);
    rr_sel = (mode == PRIO_RR0) || (mode == PRIO_RR1);
    case (mode)
      PRIO_FIX_A: ord_eff = ord_fix_a;
      PRIO_FIX_B: ord_eff = ord_fix_b;
      default:    ord_eff = ord_rr;
    endcase
  end

  always_comb begin
    gnt_id = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (gnt_q[i]) gnt_id = IDW'(i);
    end
    held    = |gnt_q;
    rel     = held && unit_done && (!(|(gnt_q & burst_mode)) || burst_last);
    rot_en  = held && unit_done && rr_sel;
    clr_vec = gnt_q & {NUM_CH{rel}};
    gnt_en  = rel || !held;
    gnt_d   = held ? '0 : pick_gnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gnt_q <= '0;
    else if (gnt_en) gnt_q <= gnt_d;
  end

  dma_arb_req_latch #(.NUM_CH(NUM_CH)) u_latch (
    .clk(clk), .rst_n(rst_n), .set_i(req_set), .clr_i(clr_vec), .pend_o(pend_q)
  );

  dma_arb_rr_order #(.NUM_CH(NUM_CH)) u_rr (
    .clk(clk), .rst_n(rst_n), .rot_en(rot_en), .rot_ch(gnt_id), .order_o(ord_rr)
  );

  dma_arb_pick #(.NUM_CH(NUM_CH)) u_pick (
    .req_i(pend_q), .order_i(ord_eff), .gnt_o(pick_gnt)
  );

  assign grant      = gnt_q;
  assign pend       = pend_q;
  assign prio_order = ord_eff;
endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk #(
  parameter int NUM_CH = 4,
  localparam int IDW = $clog2(NUM_CH)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            prio_mode,
  input logic [NUM_CH-1:0]     burst_mode,
  input logic                  unit_done,
  input logic                  burst_last,
  input logic [NUM_CH-1:0]     grant,
  input logic [NUM_CH-1:0]     pend,
  input logic [NUM_CH*IDW-1:0] prio_order
);
  logic [NUM_CH-1:0]     seen;
  logic [NUM_CH*IDW-1:0] ident;
  logic                  release_now;

  always_comb begin
    seen  = '0;
    ident = '0;
    for (int p = 0; p < NUM_CH; p++) begin
      seen[prio_order[p*IDW +: IDW]] = 1'b1;
      ident[p*IDW +: IDW] = IDW'(p);
    end
    release_now = (grant != '0) && unit_done &&
                  ((|(grant & ~burst_mode)) || burst_last);
  end

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R5
  grant_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~pend) == '0);

  // R8
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !release_now) |=> $stable(grant));

  // R6
  grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_now |=> (grant == '0));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && pend == '0) |=> (grant == '0));

  // R4
  order_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen == {NUM_CH{1'b1}});

  // R2
  fixed_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_mode == 2'b00) |-> (prio_order == ident));
endmodule

bind dma_prio_arb dma_prio_arb_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .prio_mode(prio_mode), .burst_mode(burst_mode),
  .unit_done(unit_done), .burst_last(burst_last), .grant(grant),
  .pend(pend), .prio_order(prio_order)
);

// File: tb/tb_dma_prio_arb.sv
`timescale 1ns/1ps
module tb_dma_prio_arb;
  logic       clk, rst_n;
  logic [1:0] prio_mode;
  logic [3:0] req_set, burst_mode;
  logic       unit_done, burst_last;
  logic [3:0] grant, pend;
  logic [7:0] prio_order;

  int checks = 0, errors = 0, cyc = 0;

  dma_prio_arb dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // reference model
  logic [3:0] m_pend;
  int         m_gnt;
  int         m_rr[$];

  function automatic int ord_at(int p);
    int fb[4] = '{0, 2, 3, 1};
    if (prio_mode == 2'b00) return p;
    if (prio_mode == 2'b01) return fb[p];
    return m_rr[p];
  endfunction

  function automatic logic [7:0] m_order();
    logic [7:0] v;
    for (int p = 0; p < 4; p++) v[p*2 +: 2] = 2'(ord_at(p));
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = '0;
      m_gnt  = -1;
      m_rr   = {0, 1, 2, 3};
    end else begin
      int  g, pick;
      bit  rel, rot;
      g    = m_gnt;
      pick = -1;
      rel  = (g >= 0) && unit_done && (!burst_mode[g] || burst_last);
      rot  = (g >= 0) && unit_done && prio_mode[1];
      if (g < 0) begin
        for (int p = 3; p >= 0; p--) if (m_pend[ord_at(p)]) pick = ord_at(p);
      end
      for (int i = 0; i < 4; i++) begin
        if (rel && g == i) m_pend[i] = 1'b0;
        if (req_set[i]) m_pend[i] = 1'b1;
      end
      m_gnt = (g >= 0) ? (rel ? -1 : g) : pick;
      if (rot) begin
        for (int k = 0; k < 4; k++) begin
          if (m_rr[k] == g) begin
            m_rr.delete(k);
            break;
          end
        end
        m_rr.push_back(g);
      end
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare();
    logic [3:0] eg;
    eg = (m_gnt < 0) ? 4'b0 : 4'(1 << m_gnt);
    chk("R8 grant", {4'b0, grant}, {4'b0, eg});
    chk("R5 pend", {4'b0, pend}, {4'b0, m_pend});
    chk("R4 order", prio_order, m_order());
  endtask

  task automatic step(logic [3:0] s, logic d, logic l);
    req_set    = s;
    unit_done  = d;
    burst_last = l;
    @(posedge clk);
    @(negedge clk);
    req_set   = '0;
    unit_done = 1'b0;
    burst_last = 1'b0;
    compare();
  endtask

  initial begin
    rst_n = 1'b0; prio_mode = 2'b10; req_set = '0; burst_mode = '0;
    unit_done = 1'b0; burst_last = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 grant in reset", {4'b0, grant}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 grant", {4'b0, grant}, 8'h00);
    chk("R1 pend", {4'b0, pend}, 8'h00);
    chk("R1 order", prio_order, 8'hE4);

    // fixed order A, cycle steal
    prio_mode = 2'b00;
    #0.1 chk("R2 order", prio_order, 8'hE4);
    step(4'b1110, 0, 0);
    chk("R5 latched", {4'b0, pend}, 8'h0E);
    step(0, 0, 0);
    chk("R2 pick ch1", {4'b0, grant}, 8'h02);
    step(0, 1, 0);
    chk("R6 grant drop", {4'b0, grant}, 8'h00);
    chk("R6 pend clr", {4'b0, pend}, 8'h0C);
    step(0, 0, 0);
    chk("R8 next pick ch2", {4'b0, grant}, 8'h04);
    step(0, 1, 0);
    step(0, 0, 0);
    step(0, 1, 0);

    // fixed order B
    prio_mode = 2'b01;
    #0.1 chk("R3 order", prio_order, 8'h78);
    step(4'b1010, 0, 0);
    step(0, 0, 0);
    chk("R3 pick ch3", {4'b0, grant}, 8'h08);
    step(0, 1, 0);
    step(0, 0, 0);
    chk("R3 then ch1", {4'b0, grant}, 8'h02);
    step(0, 1, 0);

    // burst
    prio_mode = 2'b00; burst_mode = 4'b0001;
    step(4'b0001, 0, 0);
    step(0, 0, 0);
    step(0, 1, 0);
    chk("R7 held grant", {4'b0, grant}, 8'h01);
    chk("R7 held pend", {4'b0, pend}, 8'h01);
    step(0, 1, 1);
    chk("R7 released", {4'b0, grant | pend}, 8'h00);
    burst_mode = '0;

    // round robin
    prio_mode = 2'b10;
    step(4'b1111, 0, 0);
    step(0, 0, 0);
    chk("R4 first ch0", {4'b0, grant}, 8'h01);
    step(0, 1, 0);
    chk("R4 rotated", prio_order, 8'h39);
    for (int k = 0; k < 6; k++) step(0, k % 2 == 1, 0);

    // idle
    step(0, 1, 0);
    chk("R9 idle grant", {4'b0, grant}, 8'h00);

    // set colliding with release
    step(4'b0100, 0, 0);
    step(0, 0, 0);
    step(4'b0100, 1, 0);
    chk("R10 pend kept", {4'b0, pend}, 8'h04);
    step(0, 0, 0);
    step(0, 1, 0);

    // random stretch
    for (int n = 0; n < 600; n++) begin
      if (n % 50 == 0) prio_mode = 2'($urandom);
      if (n % 37 == 0) burst_mode = 4'($urandom);
      step(4'($urandom) & 4'($urandom), ($urandom % 3) == 0, ($urandom % 2) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule